// File: doc/BRIEF.md
# Vector Source-B Operand Selector

This block works out the second operand of a binary vector operation from a 5-bit selector code. The operand can come from several places: the explicit register read data, one of the vector read ports that the whole bundle shares, a form built from the six 16-bit bundle immediates, or a constant held in the block itself. The result is a single 32-bit lane value, and the caller copies it to every lane.

The block is purely combinational. Alongside the operand it drives a one-hot flag vector that tells the bundle-level resource logic which shared read port, if any, the current code uses. A float/integer mode input changes how the integer constant codes are encoded. Every other code ignores it.

Immediate slot k sits at bits [16k+15:16k] of `imm_slots`. Shared port k sits at bits [32k+31:32k] of `port_data`.

Top module: `srcb_operand_sel`

## Requirements
- R1: Code 0 drives `vreg_data` onto `operand` unchanged.
- R2: Codes 1, 2 and 3 drive shared port 0, 1 and 2 onto `operand` and raise `port_used` bit 0, 1 or 2 alone. Every other code leaves `port_used` at zero.
- R3: Codes 4, 5, 6 and 7 drive the single-precision patterns 0x3F800000 (1.0), 0x40000000 (2.0), 0xBF800000 (-1.0) and 0x3F000000 (0.5), whatever the mode.
- R4: With `fp_mode` low, codes 8, 9 and 10 drive the integers +1 (0x00000001), -1 (0xFFFFFFFF) and 0.
- R5: With `fp_mode` high, codes 8, 9 and 10 drive 0x3F800000, 0xBF800000 and 0x00000000. `fp_mode` changes the result of no other code.
- R6: Codes 11 to 16 place immediate slot (code-11) in bits 15:0 and clear bits 31:16.
- R7: Codes 17 to 22 place immediate slot (code-17) in bits 31:16 and clear bits 15:0.
- R8: Codes 23 to 28 place immediate slot (code-23) in bits 15:0 and set bits 31:16 to all ones.
- R9: Codes 29, 30 and 31 drive {slot 1, slot 0}, {slot 3, slot 2} and {slot 5, slot 4}. The higher-numbered slot goes in bits 31:16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel_code | input | 5 | Source-B selector code |
| fp_mode | input | 1 | 1 selects float encoding for the integer constant codes |
| vreg_data | input | 32 | Lane value read from the explicit source register |
| port_data | input | 96 | Three shared read-port lane values, port k at [32k+31:32k] |
| imm_slots | input | 96 | Six 16-bit bundle immediates, slot k at [16k+15:16k] |
| operand | output | 32 | Resolved source-B lane value |
| port_used | output | 3 | One-hot flag of the shared port consumed |

## Verification
The assertions are evaluated whenever the inputs change. They cover the register pass-through, the one-hot port flag and its tie to port codes, the fixed fill halves of the high-half and ones forms, the exponent of the float constants, and the pair fusion. The exact constant values, the slot-to-code mapping and the absence of any `fp_mode` effect outside the integer constants can only be shown by the bench. It sweeps every code in both modes and compares each result with values it computes itself.

// File: rtl/srcb_sel_pkg.sv
package srcb_sel_pkg;
  localparam int LANE_W  = 32;
  localparam int HALF_W  = LANE_W / 2;

  localparam logic [LANE_W-1:0] F32_ONE     = 32'h3F80_0000;
  localparam logic [LANE_W-1:0] F32_TWO     = 32'h4000_0000;
  localparam logic [LANE_W-1:0] F32_NEG_ONE = 32'hBF80_0000;
  localparam logic [LANE_W-1:0] F32_HALF    = 32'h3F00_0000;

  localparam int N_FCONST = 4;
  localparam int N_ICONST = 3;

  typedef enum logic [2:0] {
    GRP_VREG,
    GRP_PORT,
    GRP_CONST,
    GRP_LOZ,
    GRP_HIZ,
    GRP_ONES,
    GRP_PAIR
  } src_grp_e;
endpackage

// File: rtl/srcb_port_mux.sv
module srcb_port_mux #(
  parameter int N_PORT    = 3,
  parameter int CODE_W    = 5,
  parameter int PORT_BASE = 1
) (
  input  logic [CODE_W-1:0]                       code,
  input  logic [N_PORT*srcb_sel_pkg::LANE_W-1:0]  port_data,
  output logic [srcb_sel_pkg::LANE_W-1:0]         port_val,
  output logic [N_PORT-1:0]                       port_used
);
  import srcb_sel_pkg::*;

  logic [N_PORT-1:0][LANE_W-1:0] ports;

  genvar k;
  generate
    for (k = 0; k < N_PORT; k++) begin : g_port
      assign ports[k]     = port_data[k*LANE_W +: LANE_W];
      assign port_used[k] = (int'(code) == PORT_BASE + k);
    end
  endgenerate

  always_comb begin
    port_val = '0;
    for (int i = 0; i < N_PORT; i++) begin
      if (port_used[i]) port_val = ports[i];
    end
  end
endmodule

// File: rtl/srcb_const_gen.sv
module srcb_const_gen #(
  parameter int CODE_W = 5,
  parameter int FBASE  = 4,
  parameter int IBASE  = 8
) (
  input  logic [CODE_W-1:0]                code,
  input  logic                             fp_mode,
  output logic [srcb_sel_pkg::LANE_W-1:0]  const_val
);
  import srcb_sel_pkg::*;

  int off;

  always_comb begin
    off       = int'(code) - FBASE;
    const_val = '0;
    case (off)
      0: const_val = F32_ONE;
      1: const_val = F32_TWO;
      2: const_val = F32_NEG_ONE;
      3: const_val = F32_HALF;
      default: begin
        case (int'(code) - IBASE)
          0: const_val = fp_mode ? F32_ONE : LANE_W'(1);
          1: const_val = fp_mode ? F32_NEG_ONE : '1;
          default: const_val = '0;
        endcase
      end
    endcase
  end

  // R3
  always_comb begin
    if (off >= 0 && off < N_FCONST)
      fconst_exp_chk: assert (const_val[30:23] != 8'h00)
        else $error("float constant has zero exponent");
  end
endmodule

// File: rtl/srcb_imm_forms.sv
module srcb_imm_forms #(
  parameter int N_IMM = 6
) (
  input  logic [N_IMM*srcb_sel_pkg::HALF_W-1:0]               imm_slots,
  output logic [N_IMM-1:0][srcb_sel_pkg::LANE_W-1:0]          lo_zero,
  output logic [N_IMM-1:0][srcb_sel_pkg::LANE_W-1:0]          hi_zero,
  output logic [N_IMM-1:0][srcb_sel_pkg::LANE_W-1:0]          ones_ext,
  output logic [N_IMM/2-1:0][srcb_sel_pkg::LANE_W-1:0]        paired
);
  import srcb_sel_pkg::*;

  localparam int N_PAIR = N_IMM / 2;

  logic [N_IMM-1:0][HALF_W-1:0] slot;

  genvar k;
  generate
    for (k = 0; k < N_IMM; k++) begin : g_slot
      assign slot[k]     = imm_slots[k*HALF_W +: HALF_W];
      assign lo_zero[k]  = {{HALF_W{1'b0}}, slot[k]};
      assign hi_zero[k]  = {slot[k], {HALF_W{1'b0}}};
      assign ones_ext[k] = {{HALF_W{1'b1}}, slot[k]};
    end
    for (k = 0; k < N_PAIR; k++) begin : g_pair
      assign paired[k] = {slot[2*k+1], slot[2*k]};
    end
  endgenerate
endmodule

// File: rtl/srcb_operand_sel.sv
module srcb_operand_sel #(
  parameter int CODE_W = 5,
  parameter int N_PORT = 3,
  parameter int N_IMM  = 6
) (
  input  logic [CODE_W-1:0]                       sel_code,
  input  logic                                    fp_mode,
  input  logic [srcb_sel_pkg::LANE_W-1:0]         vreg_data,
  input  logic [N_PORT*srcb_sel_pkg::LANE_W-1:0]  port_data,
  input  logic [N_IMM*srcb_sel_pkg::HALF_W-1:0]   imm_slots,
  output logic [srcb_sel_pkg::LANE_W-1:0]         operand,
  output logic [N_PORT-1:0]                       port_used
);
  import srcb_sel_pkg::*;

  localparam int PORT_BASE   = 1;
  localparam int FCONST_BASE = PORT_BASE + N_PORT;
  localparam int ICONST_BASE = FCONST_BASE + N_FCONST;
  localparam int LOZ_BASE    = ICONST_BASE + N_ICONST;
  localparam int HIZ_BASE    = LOZ_BASE + N_IMM;
  localparam int ONES_BASE   = HIZ_BASE + N_IMM;
  localparam int PAIR_BASE   = ONES_BASE + N_IMM;
  localparam int N_PAIR      = N_IMM / 2;
  localparam int IDX_W       = (N_IMM > 1) ? $clog2(N_IMM) : 1;
  localparam int PIDX_W      = (N_PAIR > 1) ? $clog2(N_PAIR) : 1;

  logic [LANE_W-1:0]              port_val;
  logic [LANE_W-1:0]              const_val;
  logic [N_IMM-1:0][LANE_W-1:0]   lo_zero, hi_zero, ones_ext;
  logic [N_PAIR-1:0][LANE_W-1:0]  paired;
  src_grp_e                       grp;
  logic [IDX_W-1:0]               imm_idx;
  logic [PIDX_W-1:0]              pair_idx;
  int                             code_i;

  srcb_port_mux #(.N_PORT(N_PORT), .CODE_W(CODE_W), .PORT_BASE(PORT_BASE)) u_port_mux (
    .code      (sel_code),
    .port_data (port_data),
    .port_val  (port_val),
    .port_used (port_used)
  );

  srcb_const_gen #(.CODE_W(CODE_W), .FBASE(FCONST_BASE), .IBASE(ICONST_BASE)) u_const_gen (
    .code      (sel_code),
    .fp_mode   (fp_mode),
    .const_val (const_val)
  );

  srcb_imm_forms #(.N_IMM(N_IMM)) u_imm_forms (
    .imm_slots (imm_slots),
    .lo_zero   (lo_zero),
    .hi_zero   (hi_zero),
    .ones_ext  (ones_ext),
    .paired    (paired)
  );

  // group decode and slot offset
  always_comb begin
    code_i  = int'(sel_code);
    grp     = GRP_VREG;
    imm_idx = '0;
    if (code_i >= PAIR_BASE) begin
      grp = GRP_PAIR;
    end else if (code_i >= ONES_BASE) begin
      grp     = GRP_ONES;
      imm_idx = IDX_W'(code_i - ONES_BASE);
    end else if (code_i >= HIZ_BASE) begin
      grp     = GRP_HIZ;
      imm_idx = IDX_W'(code_i - HIZ_BASE);
    end else if (code_i >= LOZ_BASE) begin
      grp     = GRP_LOZ;
      imm_idx = IDX_W'(code_i - LOZ_BASE);
    end else if (code_i >= FCONST_BASE) begin
      grp = GRP_CONST;
    end else if (code_i >= PORT_BASE) begin
      grp = GRP_PORT;
    end
    pair_idx = PIDX_W'(code_i - PAIR_BASE);
  end

  // final operand select
  always_comb begin
    case (grp)
      GRP_PORT:  operand = port_val;
      GRP_CONST: operand = const_val;
      GRP_LOZ:   operand = lo_zero[imm_idx];
      GRP_HIZ:   operand = hi_zero[imm_idx];
      GRP_ONES:  operand = ones_ext[imm_idx];
      GRP_PAIR:  operand = paired[pair_idx];
      default:   operand = vreg_data;
    endcase
  end

  // R1
  always_comb begin
    if (sel_code == '0)
      vreg_pass_chk: assert (operand == vreg_data)
        else $error("register code did not pass register data");
  end

  // R2
  always_comb begin
    port_onehot_chk: assert ($onehot0(port_used))
      else $error("more than one shared port flagged");
    if (port_used != '0)
      port_code_chk: assert (code_i >= PORT_BASE && code_i < FCONST_BASE)
        else $error("port flagged for a non-port code");
  end

  // R7
  always_comb begin
    if (code_i >= HIZ_BASE && code_i < ONES_BASE)
      hiz_low_clear_chk: assert (operand[HALF_W-1:0] == '0)
        else $error("high-half form has nonzero low half");
  end

  // R8
  always_comb begin
    if (code_i >= ONES_BASE && code_i < PAIR_BASE)
      ones_fill_chk: assert (operand[LANE_W-1:HALF_W] == '1)
        else $error("ones form upper half not all ones");
  end

  // R9
  always_comb begin
    if (code_i == PAIR_BASE)
      pair0_fuse_chk: assert (operand == imm_slots[2*HALF_W-1:0])
        else $error("first pair not fused slot1:slot0");
  end
endmodule

// File: tb/srcb_operand_sel_bench.sv
module srcb_operand_sel_bench;
  logic        clk;
  logic        rst_n;
  logic [4:0]  sel_code;
  logic        fp_mode;
  logic [31:0] vreg_data;
  logic [95:0] port_data;
  logic [95:0] imm_slots;
  logic [31:0] operand;
  logic [2:0]  port_used;

  int checks;
  int failures;
  bit done;

  srcb_operand_sel u_srcb_operand_sel (
    .sel_code  (sel_code),
    .fp_mode   (fp_mode),
    .vreg_data (vreg_data),
    .port_data (port_data),
    .imm_slots (imm_slots),
    .operand   (operand),
    .port_used (port_used)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] slot_of(logic [95:0] im, int k);
    return im[16*k +: 16];
  endfunction

  function automatic logic [31:0] exp_op(int c, bit fp, logic [31:0] vr,
                                         logic [95:0] pd, logic [95:0] im);
    if (c == 0) return vr;
    if (c <= 3) return pd[32*(c-1) +: 32];
    case (c)
      4:  return 32'h3F800000;
      5:  return 32'h40000000;
      6:  return 32'hBF800000;
      7:  return 32'h3F000000;
      8:  return fp ? 32'h3F800000 : 32'h00000001;
      9:  return fp ? 32'hBF800000 : 32'hFFFFFFFF;
      10: return 32'h00000000;
      default: ;
    endcase
    if (c <= 16) return {16'h0000, slot_of(im, c-11)};
    if (c <= 22) return {slot_of(im, c-17), 16'h0000};
    if (c <= 28) return {16'hFFFF, slot_of(im, c-23)};
    return {slot_of(im, 2*(c-29)+1), slot_of(im, 2*(c-29))};
  endfunction

  function automatic logic [2:0] exp_used(int c);
    if (c >= 1 && c <= 3) return 3'(1 << (c-1));
    return 3'b000;
  endfunction

  function automatic string req_of(int c, bit fp);
    if (c == 0) return "R1";
    if (c <= 3) return "R2";
    if (c <= 7) return "R3";
    if (c <= 10) return fp ? "R5" : "R4";
    if (c <= 16) return "R6";
    if (c <= 22) return "R7";
    if (c <= 28) return "R8";
    return "R9";
  endfunction

  task automatic apply_and_check(int c, bit fp, logic [31:0] vr,
                                 logic [95:0] pd, logic [95:0] im);
    logic [31:0] eo;
    logic [2:0]  eu;
    @(negedge clk);
    sel_code  = 5'(c);
    fp_mode   = fp;
    vreg_data = vr;
    port_data = pd;
    imm_slots = im;
    @(posedge clk);
    #1;
    eo = exp_op(c, fp, vr, pd, im);
    eu = exp_used(c);
    checks++;
    if (operand !== eo) begin
      failures++;
      $display("FAIL %s code=%0d fp=%0d operand actual=%h expected=%h",
               req_of(c, fp), c, fp, operand, eo);
    end
    checks++;
    if (port_used !== eu) begin
      failures++;
      $display("FAIL R2 code=%0d port_used actual=%b expected=%b", c, port_used, eu);
    end
  endtask

  function automatic logic [95:0] rnd96();
    return {$urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    int seed_dummy;
    checks    = 0;
    failures  = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    sel_code  = '0;
    fp_mode   = 1'b0;
    vreg_data = '0;
    port_data = '0;
    imm_slots = '0;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    // reset state, R1: all-zero inputs give zero operand and no port use
    checks++;
    if (operand !== 32'h0 || port_used !== 3'b000) begin
      failures++;
      $display("FAIL R1 reset state actual=%h/%b expected=00000000/000", operand, port_used);
    end

    // directed sweep of every code, both modes, distinctive slot values
    for (int fp = 0; fp < 2; fp++) begin
      for (int c = 0; c < 32; c++) begin
        apply_and_check(c, fp[0], 32'hCAFE_F00D,
                        {32'h2222_2222, 32'h1111_1111, 32'h0000_AAAA},
                        {16'h5555, 16'h4444, 16'h3333, 16'h2222, 16'h1111, 16'h8001});
      end
    end

    // R6/R7/R8/R9 corner: all-ones and all-zero slots
    for (int c = 11; c < 32; c++) begin
      apply_and_check(c, 1'b0, 32'h0, 96'h0, {96{1'b1}});
      apply_and_check(c, 1'b1, 32'hFFFF_FFFF, {96{1'b1}}, 96'h0);
    end

    // R5: fp_mode leaves non-integer codes unchanged (random data)
    for (int i = 0; i < 200; i++) begin
      logic [31:0] vr;
      logic [95:0] pd, im;
      int c;
      vr = $urandom();
      pd = rnd96();
      im = rnd96();
      c  = int'($urandom_range(31, 0));
      apply_and_check(c, 1'b0, vr, pd, im);
      apply_and_check(c, 1'b1, vr, pd, im);
    end

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      apply_and_check(int'($urandom_range(31, 0)), 1'($urandom()), $urandom(),
                      rnd96(), rnd96());
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule